// File: doc/BRIEF.md
# Real-Time Clock Indexed Register Port

This block is the host-facing register front end of a real-time clock. The host sees two byte addresses. A write to the even address chooses one of 128 register entries. Reads and writes at the odd address then reach the chosen entry. Most entries are plain byte storage. The four status/control entries at indices 0x0A to 0x0D have their own rules: a read-only update-in-progress bit, a write-protected flag register, a constant validity byte, and a control register whose write re-evaluates the interrupt line.

The clock's timing blocks sit beside this port. They pulse flag-set inputs for the update-ended, alarm and periodic events. They also drive the update-in-progress bit through set and clear inputs. In return they read the control registers from two export ports. The interrupt output follows the IRQF bit of the flag register. A separate device-reset pulse clears the interrupt enables and the pending flags without disturbing the stored time or general bytes.

Top module: `rtc_regport`

## Requirements
- R1: After rst_n is held low, register A (index 0x0A) reads 0x26, B (0x0B) reads 0x02, C (0x0C) reads 0x00 and D (0x0D) reads 0x80, and irq_o is low.
- R2: A read strobe at the even address (bus_addr_i=0) returns 0xFF on bus_rdata_o.
- R3: A write at the even address stores bits [6:0] of the data as the index; odd-address accesses to a general index (any index other than 0x0A to 0x0D) store and return a byte.
- R4: Writes to register C and register D leave their read values unchanged.
- R5: Bit 7 of register A (UIP) ignores bus writes; uip_set_i sets it and uip_clr_i clears it.
- R6: A write to register B with bit 7 (SET) high stores bit 4 (UIE) as 0 and clears UIP; ctl_b_o and ctl_a_o show the stored values.
- R7: uf_set_i, af_set_i and pf_set_i set C bits 4, 5 and 6. When a newly set flag's enable is set, C bit 7 (IRQF) is set and irq_o goes high. The enables are B bit 4 for update-ended, bit 5 for alarm and bit 6 for periodic.
- R8: Reading register C returns its current contents, then clears it to 0x00 and drops irq_o.
- R9: After a write to register B, irq_o and IRQF are high exactly when some flag in C bits 6:4 has its enable set in the new B value; otherwise both go low.
- R10: A dev_rst_i pulse clears B bits 6, 5 and 3 (PIE, AIE, square-wave enable), keeps the other B bits, and clears register C and irq_o.
- R11: A dev_rst_i pulse clears general byte 0x0F unless it holds 0xFE, in which case it is kept.
- R12: A flag set in the same cycle as a read of register C is kept in C after the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| dev_rst_i | input | 1 | Device reset pulse (partial clear) |
| bus_sel_i | input | 1 | Single-cycle access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 1 | 0 = index port, 1 = data port |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, valid during the strobe |
| uf_set_i | input | 1 | Update-ended flag set pulse |
| af_set_i | input | 1 | Alarm flag set pulse |
| pf_set_i | input | 1 | Periodic flag set pulse |
| uip_set_i | input | 1 | Set update-in-progress |
| uip_clr_i | input | 1 | Clear update-in-progress |
| ctl_a_o | output | 8 | Register A contents for the timing blocks |
| ctl_b_o | output | 8 | Register B contents for the timing blocks |
| irq_o | output | 1 | Combined interrupt, follows IRQF |

## Verification
The bench builds the block with its default index width of 7 bits, which gives 128 entries. This lets it write an index byte with bit 7 set and confirm that the entry reached is 0x0F. It also brings the shutdown byte at 0x0F within reach, so both branches of the device-reset rule can be tested. The default width also places the status entries at their fixed indices, so the bench can test flag and enable interplay, including a flag set in the same cycle as a register C read.

// File: rtl/rtc_regport_pkg.sv
// Package: shared constants for the RTC register port.
// Assumes 8-bit registers and status entries at fixed indices 0x0A..0x0D.
package rtc_regport_pkg;
    localparam int REG_W      = 8;
    localparam int IDX_STAT_A = 'h0A;
    localparam int IDX_STAT_B = 'h0B;
    localparam int IDX_STAT_C = 'h0C;
    localparam int IDX_STAT_D = 'h0D;
    localparam int IDX_SHUT   = 'h0F;
    localparam logic [REG_W-1:0] SHUT_KEEP = 8'hFE;
    localparam logic [REG_W-1:0] RST_A     = 8'h26;
    localparam logic [REG_W-1:0] RST_B     = 8'h02;
    localparam logic [REG_W-1:0] VAL_D     = 8'h80;
    localparam logic [REG_W-1:0] IDX_RDVAL = 8'hFF;
    // register B bit positions
    localparam int B_SET  = 7;
    localparam int B_PIE  = 6;
    localparam int B_AIE  = 5;
    localparam int B_UIE  = 4;
    localparam int B_SQWE = 3;
    // register A / C bit positions
    localparam int A_UIP  = 7;
    localparam int C_IRQF = 7;
endpackage

// File: rtl/rtc_index_reg.sv
// Index latch: holds the entry number chosen through the even address.
// Assumes the caller passes only the low IDX_W data bits.
module rtc_index_reg #(
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [IDX_W-1:0] din,
    output logic [IDX_W-1:0] idx
);
    // capture a new index on an even-address write
    always_ff @(posedge clk) begin
        if (!rst_n)    idx <= '0;
        else if (load) idx <= din;
    end
endmodule

// File: rtl/rtc_gp_store.sv
// General-purpose byte storage for all entries; status entries are never
// written here (the top decodes them away). Handles the shutdown-byte rule.
module rtc_gp_store
    import rtc_regport_pkg::*;
#(
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dev_rst,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata
);
    localparam int NUM_REGS = 1 << IDX_W;

    logic [REG_W-1:0] mem [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_ent
        if (g == IDX_SHUT) begin : g_shut
            // shutdown byte: survives device reset only when it holds the keep code
            always_ff @(posedge clk) begin
                if (!rst_n)                             mem[g] <= '0;
                else if (dev_rst && mem[g] != SHUT_KEEP) mem[g] <= '0;
                else if (!dev_rst && we && int'(idx) == g) mem[g] <= wdata;
            end
        end else begin : g_plain
            // plain byte: loaded by a data-port write
            always_ff @(posedge clk) begin
                if (!rst_n)                       mem[g] <= '0;
                else if (we && int'(idx) == g)    mem[g] <= wdata;
            end
        end
    end

    assign rdata = mem[idx];

    // R11
    shut_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_rst && mem[IDX_SHUT] == SHUT_KEEP) |=> mem[IDX_SHUT] == SHUT_KEEP);
    // R11
    shut_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_rst && mem[IDX_SHUT] != SHUT_KEEP) |=> mem[IDX_SHUT] == '0);
endmodule

// File: rtl/rtc_status_regs.sv
// Status registers A, B and C with their special write/read rules and the
// interrupt decision. Assumes at most one bus strobe per cycle; flag inputs
// may coincide with any access.
module rtc_status_regs
    import rtc_regport_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dev_rst,
    input  logic             wr_a,
    input  logic             wr_b,
    input  logic             rd_c,
    input  logic [REG_W-1:0] wdata,
    input  logic             uf_set,
    input  logic             af_set,
    input  logic             pf_set,
    input  logic             uip_set,
    input  logic             uip_clr,
    output logic [REG_W-1:0] a_q,
    output logic [REG_W-1:0] b_q,
    output logic [REG_W-1:0] c_q
);
    logic [2:0]       flag_set;      // {PF, AF, UF}
    logic [2:0]       flag_base;     // flags left after a possible read clear
    logic [2:0]       flag_nxt;
    logic [2:0]       flag_new;
    logic [REG_W-1:0] b_nxt;
    logic             irqf_nxt;
    logic             uip_nxt;

    assign flag_set = {pf_set, af_set, uf_set};

    // next B value, UIP bit and flag/IRQF decision
    always_comb begin
        b_nxt = b_q;
        if (wr_b) begin
            b_nxt = wdata;
            if (wdata[B_SET]) b_nxt[B_UIE] = 1'b0;
        end
        uip_nxt = a_q[A_UIP];
        if (uip_set) uip_nxt = 1'b1;
        if (uip_clr) uip_nxt = 1'b0;
        if (wr_b && wdata[B_SET]) uip_nxt = 1'b0;
        flag_base = rd_c ? 3'b000 : c_q[6:4];
        flag_nxt  = flag_base | flag_set;
        flag_new  = flag_set & ~flag_base;
        if (wr_b) irqf_nxt = |(b_nxt[6:4] & flag_nxt);
        else      irqf_nxt = (c_q[C_IRQF] & ~rd_c) | (|(flag_new & b_q[6:4]));
    end

    // register A: rate/divider fields from the bus, UIP from the timing side
    always_ff @(posedge clk) begin
        if (!rst_n)    a_q <= RST_A;
        else if (wr_a) a_q <= {uip_nxt, wdata[6:0]};
        else           a_q <= {uip_nxt, a_q[6:0]};
    end

    // register B: control bits, partial clear on device reset
    always_ff @(posedge clk) begin
        if (!rst_n)       b_q <= RST_B;
        else if (dev_rst) b_q <= b_q & ~(8'(1) << B_PIE | 8'(1) << B_AIE | 8'(1) << B_SQWE);
        else              b_q <= b_nxt;
    end

    // register C: flags and IRQF, never written by the bus
    always_ff @(posedge clk) begin
        if (!rst_n || dev_rst) c_q <= '0;
        else                   c_q <= {irqf_nxt, flag_nxt, 4'b0000};
    end

    // R6
    set_forces_uie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_b && wdata[B_SET] && !dev_rst) |=> (!b_q[B_UIE] && !a_q[A_UIP]));
    // R5
    uip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_a && !uip_set && !uip_clr && !dev_rst) |=> a_q[A_UIP] == $past(a_q[A_UIP]));
    // R8
    rdc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_c && !uf_set && !af_set && !pf_set && !wr_b) |=> c_q == '0);
    // R9
    bwr_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_b && !dev_rst) |=> c_q[C_IRQF] == |(b_q[6:4] & c_q[6:4]));
    // R4
    c_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_c && !wr_b && !dev_rst && !uf_set && !af_set && !pf_set) |=> $stable(c_q));
endmodule

// File: rtl/rtc_regport.sv
// Top: two-address byte port onto the 128-entry RTC register file.
// Decodes the strobe into index, status and general-storage accesses and
// drives the read mux. Assumes single-cycle strobes and combinational read.
module rtc_regport
    import rtc_regport_pkg::*;
#(
    parameter int IDX_W = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dev_rst_i,
    input  logic       bus_sel_i,
    input  logic       bus_wr_i,
    input  logic       bus_addr_i,
    input  logic [7:0] bus_wdata_i,
    output logic [7:0] bus_rdata_o,
    input  logic       uf_set_i,
    input  logic       af_set_i,
    input  logic       pf_set_i,
    input  logic       uip_set_i,
    input  logic       uip_clr_i,
    output logic [7:0] ctl_a_o,
    output logic [7:0] ctl_b_o,
    output logic       irq_o
);
    logic [IDX_W-1:0] idx;
    logic             data_wr, data_rd, is_status;
    logic [REG_W-1:0] a_q, b_q, c_q, gp_rdata;

    assign data_wr   = bus_sel_i &  bus_wr_i & bus_addr_i;
    assign data_rd   = bus_sel_i & ~bus_wr_i & bus_addr_i;
    assign is_status = int'(idx) >= IDX_STAT_A && int'(idx) <= IDX_STAT_D;

    rtc_index_reg #(.IDX_W(IDX_W)) idx_i (
        .clk (clk), .rst_n (rst_n),
        .load (bus_sel_i & bus_wr_i & ~bus_addr_i),
        .din  (bus_wdata_i[IDX_W-1:0]),
        .idx  (idx)
    );

    rtc_status_regs stat_i (
        .clk (clk), .rst_n (rst_n), .dev_rst (dev_rst_i),
        .wr_a (data_wr && int'(idx) == IDX_STAT_A),
        .wr_b (data_wr && int'(idx) == IDX_STAT_B),
        .rd_c (data_rd && int'(idx) == IDX_STAT_C),
        .wdata (bus_wdata_i),
        .uf_set (uf_set_i), .af_set (af_set_i), .pf_set (pf_set_i),
        .uip_set (uip_set_i), .uip_clr (uip_clr_i),
        .a_q (a_q), .b_q (b_q), .c_q (c_q)
    );

    rtc_gp_store #(.IDX_W(IDX_W)) gp_i (
        .clk (clk), .rst_n (rst_n), .dev_rst (dev_rst_i),
        .we (data_wr && !is_status),
        .idx (idx), .wdata (bus_wdata_i), .rdata (gp_rdata)
    );

    // read mux: index port reads a constant, data port picks the entry
    always_comb begin
        if (!bus_addr_i)                     bus_rdata_o = IDX_RDVAL;
        else if (int'(idx) == IDX_STAT_A)    bus_rdata_o = a_q;
        else if (int'(idx) == IDX_STAT_B)    bus_rdata_o = b_q;
        else if (int'(idx) == IDX_STAT_C)    bus_rdata_o = c_q;
        else if (int'(idx) == IDX_STAT_D)    bus_rdata_o = VAL_D;
        else                                 bus_rdata_o = gp_rdata;
    end

    assign ctl_a_o = a_q;
    assign ctl_b_o = b_q;
    assign irq_o   = c_q[C_IRQF];

    // R10
    devrst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dev_rst_i |=> (!irq_o && (ctl_b_o & 8'h68) == 8'h00));
    // R7
    flag_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uf_set_i && ctl_b_o[B_UIE] && !dev_rst_i && !(bus_sel_i && bus_wr_i)) |=> irq_o);
endmodule

// File: tb/rtc_regport_tb_top.sv
// Directed bench for rtc_regport: one task per scenario.
module rtc_regport_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dev_rst_i = 1'b0;
    logic       bus_sel_i = 1'b0, bus_wr_i = 1'b0, bus_addr_i = 1'b0;
    logic [7:0] bus_wdata_i = 8'h00;
    logic [7:0] bus_rdata_o, ctl_a_o, ctl_b_o;
    logic       uf_set_i = 1'b0, af_set_i = 1'b0, pf_set_i = 1'b0;
    logic       uip_set_i = 1'b0, uip_clr_i = 1'b0;
    logic       irq_o;

    int  n_chk = 0, n_bad = 0;
    bit  done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    rtc_regport dut_i (.*);

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic bus_wr(logic a, logic [7:0] d);
        @(negedge clk); bus_sel_i = 1; bus_wr_i = 1; bus_addr_i = a; bus_wdata_i = d;
        @(negedge clk); bus_sel_i = 0; bus_wr_i = 0;
    endtask

    task automatic bus_rd(logic a, output logic [7:0] d);
        @(negedge clk); bus_sel_i = 1; bus_wr_i = 0; bus_addr_i = a;
        #2 d = bus_rdata_o;
        @(negedge clk); bus_sel_i = 0;
    endtask

    task automatic wr_reg(logic [7:0] i, logic [7:0] d);
        bus_wr(0, i); bus_wr(1, d);
    endtask

    task automatic rd_reg(logic [7:0] i, output logic [7:0] d);
        bus_wr(0, i); bus_rd(1, d);
    endtask

    task automatic pulse(int which);  // 0 uf,1 af,2 pf,3 uip set,4 uip clr,5 dev rst
        @(negedge clk);
        case (which)
            0: uf_set_i = 1; 1: af_set_i = 1; 2: pf_set_i = 1;
            3: uip_set_i = 1; 4: uip_clr_i = 1; default: dev_rst_i = 1;
        endcase
        @(negedge clk);
        {uf_set_i, af_set_i, pf_set_i, uip_set_i, uip_clr_i, dev_rst_i} = '0;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rd_reg(8'h0A, v); check("R1 A", v, 8'h26);
        rd_reg(8'h0B, v); check("R1 B", v, 8'h02);
        rd_reg(8'h0C, v); check("R1 C", v, 8'h00);
        rd_reg(8'h0D, v); check("R1 D", v, 8'h80);
        check("R1 irq", {7'd0, irq_o}, 8'h00);
    endtask

    task automatic t_index;
        logic [7:0] v;
        bus_rd(0, v); check("R2 even read", v, 8'hFF);
        wr_reg(8'h8F, 8'h5A);            // bit 7 dropped -> entry 0x0F
        rd_reg(8'h0F, v); check("R3 index mask", v, 8'h5A);
        wr_reg(8'h40, 8'hC3);
        rd_reg(8'h40, v); check("R3 gp byte", v, 8'hC3);
    endtask

    task automatic t_ro;
        logic [7:0] v;
        wr_reg(8'h0C, 8'hFF);
        rd_reg(8'h0C, v); check("R4 C write", v, 8'h00);
        check("R4 irq", {7'd0, irq_o}, 8'h00);
        wr_reg(8'h0D, 8'h00);
        rd_reg(8'h0D, v); check("R4 D write", v, 8'h80);
    endtask

    task automatic t_uip;
        logic [7:0] v;
        wr_reg(8'h0A, 8'hFF);
        rd_reg(8'h0A, v); check("R5 uip not writable", v, 8'h7F);
        pulse(3);
        wr_reg(8'h0A, 8'h26);
        rd_reg(8'h0A, v); check("R5 uip kept", v, 8'hA6);
        pulse(4);
        check("R5 uip cleared", ctl_a_o, 8'h26);
    endtask

    task automatic t_set;
        logic [7:0] v;
        pulse(3);
        wr_reg(8'h0B, 8'h92);
        rd_reg(8'h0B, v); check("R6 uie forced", v, 8'h82);
        check("R6 ctl_b", ctl_b_o, 8'h82);
        check("R6 uip cleared", ctl_a_o, 8'h26);
        wr_reg(8'h0B, 8'h02);
    endtask

    task automatic t_flags;
        logic [7:0] v;
        wr_reg(8'h0B, 8'h12);
        bus_wr(0, 8'h0C);
        pulse(0);
        check("R7 irq uf", {7'd0, irq_o}, 8'h01);
        bus_rd(1, v); check("R8 read C", v, 8'h90);
        check("R8 irq low", {7'd0, irq_o}, 8'h00);
        bus_rd(1, v); check("R8 cleared", v, 8'h00);
        wr_reg(8'h0B, 8'h02);
        bus_wr(0, 8'h0C);
        pulse(2);
        check("R7 no enable irq", {7'd0, irq_o}, 8'h00);
        bus_rd(1, v); check("R7 pf flag", v, 8'h40);
    endtask

    task automatic t_pending;
        logic [7:0] v;
        pulse(1);
        check("R9 af masked", {7'd0, irq_o}, 8'h00);
        wr_reg(8'h0B, 8'h22);
        check("R9 enable fires", {7'd0, irq_o}, 8'h01);
        rd_reg(8'h0C, v); check("R9 C after enable", v, 8'hA0);
        wr_reg(8'h0B, 8'h42);
        pulse(2);
        check("R9 pf irq", {7'd0, irq_o}, 8'h01);
        wr_reg(8'h0B, 8'h02);
        check("R9 disable drops", {7'd0, irq_o}, 8'h00);
        rd_reg(8'h0C, v); check("R9 irqf cleared", v, 8'h40);
    endtask

    task automatic t_devrst;
        logic [7:0] v;
        wr_reg(8'h0B, 8'h7E);
        pulse(0);
        check("R10 pre irq", {7'd0, irq_o}, 8'h01);
        wr_reg(8'h0F, 8'hFE);
        pulse(5);
        check("R10 irq", {7'd0, irq_o}, 8'h00);
        rd_reg(8'h0B, v); check("R10 B", v, 8'h16);
        rd_reg(8'h0C, v); check("R10 C", v, 8'h00);
        rd_reg(8'h0F, v); check("R11 keep", v, 8'hFE);
        rd_reg(8'h40, v); check("R10 gp kept", v, 8'hC3);
        wr_reg(8'h0F, 8'h33);
        pulse(5);
        rd_reg(8'h0F, v); check("R11 clear", v, 8'h00);
        wr_reg(8'h0B, 8'h02);
    endtask

    task automatic t_race;
        logic [7:0] v;
        wr_reg(8'h0B, 8'h12);
        bus_wr(0, 8'h0C);
        pulse(0);
        @(negedge clk); bus_sel_i = 1; bus_wr_i = 0; bus_addr_i = 1; pf_set_i = 1;
        #2 v = bus_rdata_o;
        @(negedge clk); bus_sel_i = 0; pf_set_i = 0;
        check("R12 read value", v, 8'h90);
        bus_rd(1, v); check("R12 pf kept", v, 8'h40);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset(); t_index(); t_ro(); t_uip(); t_set();
        t_flags(); t_pending(); t_devrst(); t_race();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int k = 0; k < 20000; k++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule